// File: doc/BRIEF.md
# Byte-to-Word Packing DMA Channel

A single-channel memory-to-memory transfer engine for a 16-bit bus. Software loads a source pointer, a destination pointer, a byte count and a mode, then pulses `start`. In byte-to-word mode the channel fetches two bytes from the source side and writes them to the destination as one 16-bit word. In word mode it copies one word per read/write pair. An optional step-by-two source mode keeps every byte fetch on the same byte lane. This suits a byte peripheral that sits on only one half of the bus.

A transfer stops when the count runs out, when the peripheral raises `done_in`, or when the bus answers with an error. The stop cause is recorded in a small status register whose bits software clears by writing ones. A channel-reset input abandons the transfer and wipes the status. When the count runs out, the channel itself pulses `done_drv` for one cycle.

Top module: `bpk_dma_channel`

## Requirements
- R1: After synchronous reset `busy`, `bus_req`, `done_drv` and all of `status` are 0.
- R2: A `start` pulse while idle latches `cfg_src`, `cfg_dst`, `cfg_count`, `cfg_byte_mode` and `cfg_src_step2`. A `start` while `busy` is 1 is ignored and leaves the running transfer's addresses unchanged.
- R3: In byte mode (`cfg_byte_mode`=1) each destination word costs two source reads followed by one write. The first byte read goes to `bus_wdata[15:8]` and the second to `bus_wdata[7:0]`. A byte is taken from `bus_rdata[15:8]` when the address is even and from `bus_rdata[7:0]` when it is odd.
- R4: The source pointer advances after each read: by 1 in byte mode, by 2 in byte mode with `cfg_src_step2`=1, and by 2 in word mode. The destination pointer advances by 2 after each write.
- R5: The count drops by 1 per byte read, or by 2 per word read in word mode. If the count is 0 after a write, the channel stops, sets `status[0]` (finished) and drives `done_drv` high for exactly one cycle.
- R6: If the count is 0 before a transfer starts (or below 2 in word mode), the channel stops with `status[0]` and a `done_drv` pulse and issues no bus cycle. If a first byte read leaves the count at 0, that byte is discarded and the channel stops the same way without a write.
- R7: If `done_in` is 1 when a second byte read, a word read or a write is acknowledged, the current word is still written. The channel then stops with `status[0]` and no `done_drv` pulse, even when the count also reached 0.
- R8: If `done_in` is 1 when the first byte read of a pair is acknowledged in byte mode, the channel stops without writing and sets `status[3]` (unsynchronized done) but not `status[0]`.
- R9: `bus_berr` during a read sets `status[2]` and stops the channel at once, with no further request. `bus_berr` takes precedence over `bus_ack`.
- R10: `bus_berr` during a write sets `status[1]` and stops the channel at once.
- R11: A `clr_wr` pulse clears each status bit whose `clr_mask` bit is 1 and leaves the others. `status[7:4]` always read 0.
- R12: `chan_rst` returns the channel to idle within one cycle, drops `bus_req` and clears all status bits.
- R13: Once raised, `bus_req` stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until `bus_ack` or `bus_berr` ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (idle only) |
| chan_rst | input | 1 | Abandon transfer, clear status |
| cfg_byte_mode | input | 1 | 1: byte source packed into word writes; 0: word copy |
| cfg_src_step2 | input | 1 | Byte mode: source steps by 2 |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Byte count |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask for status[3:0] |
| status | output | 8 | {0000, unsync done, read error, write error, finished} |
| busy | output | 1 | Transfer in progress |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Cycle completed |
| bus_berr | input | 1 | Cycle ended in error |
| done_in | input | 1 | External end-of-block from the peripheral |
| done_drv | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The bench aims at the edges of the count and of the packing. An odd count must end after a lone byte read with no write, so a design that writes a half-filled word shows an extra write. A zero count must produce no bus cycle at all. Steps of two from an odd address must pick the low lane every time; a wrong lane choice or step shows up as wrong write data or read addresses. External done is raised at the first read of a pair, at the second read and at a write, where a design that mixes up the unsynchronized and normal cases reports the wrong status bit, and one that lets count expiry win at the same write gives a spurious `done_drv` pulse. Errors are injected at the read and write phases, with and without wait states, so swapped error bits, a leftover request after an error, or an address that moves while waiting all give a visible mismatch.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
    localparam int STAT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_RD1,
        ST_RD2,
        ST_WR
    } seq_state_e;

    // bit3 unsync done, bit2 read error, bit1 write error, bit0 finished
    typedef struct packed {
        logic dns;
        logic src_err;
        logic dst_err;
        logic fin;
    } stat_t;

    typedef struct packed {
        logic       load;
        logic       src_adv;
        logic       dst_adv;
        logic [1:0] cnt_dec;
    } ptr_ctl_t;

    function automatic logic [LANE_W-1:0] pick_lane(input logic [BUS_W-1:0] w,
                                                     input logic odd);
        return odd ? w[LANE_W-1:0] : w[BUS_W-1:LANE_W];
    endfunction

    function automatic logic [1:0] src_step(input logic byte_mode,
                                            input logic step2);
        if (!byte_mode) return 2'd2;
        return step2 ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/bpk_ptrs.sv
module bpk_ptrs
    import bpk_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ptr_ctl_t      ctl,
    input  logic [1:0]    src_inc,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] cnt
);

    localparam logic [AW-1:0] DST_STEP = AW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            cnt     <= '0;
        end else if (ctl.load) begin
            src_ptr <= src_in;
            dst_ptr <= dst_in;
            cnt     <= cnt_in;
        end else begin
            if (ctl.src_adv) src_ptr <= src_ptr + AW'(src_inc);
            if (ctl.dst_adv) dst_ptr <= dst_ptr + DST_STEP;
            cnt <= cnt - CW'(ctl.cnt_dec);
        end
    end

    // R5: the count only moves down between loads
    assert_cnt_down_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/bpk_pack.sv
module bpk_pack
    import bpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_hi,
    input  logic             cap_lo,
    input  logic             cap_word,
    input  logic             odd,
    input  logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] pk_word
);

    logic [LANE_W-1:0] lane;
    assign lane = pick_lane(rdata, odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            pk_word <= '0;
        end else if (cap_word) begin
            pk_word <= rdata;
        end else begin
            if (cap_hi) pk_word[BUS_W-1:LANE_W] <= lane;
            if (cap_lo) pk_word[LANE_W-1:0]     <= lane;
        end
    end

    // R3: the first byte of a pair lands in the upper half
    assert_hi_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_hi && !cap_word) |=> (pk_word[BUS_W-1:LANE_W] == $past(odd ? rdata[LANE_W-1:0] : rdata[BUS_W-1:LANE_W])));

endmodule

// File: rtl/bpk_status.sv
module bpk_status
    import bpk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t set,
    input  logic  clr_wr,
    input  stat_t clr_mask,
    input  logic  chan_rst,
    output stat_t stat
);

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~(clr_wr ? clr_mask : stat_t'('0))) | set;
        end
    end

    // R11: a masked clear removes the bit unless a new event sets it
    assert_w1c_fin_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_mask.fin && !set.fin) |=> !stat.fin);
    assert_w1c_src_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_mask.src_err && !set.src_err) |=> !stat.src_err);

    // R12: channel reset wipes every status bit
    assert_chan_rst_R12: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (stat == '0));

endmodule

// File: rtl/bpk_seq.sv
module bpk_seq
    import bpk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          chan_rst,
    input  logic          cfg_byte_mode,
    input  logic          cfg_src_step2,
    input  logic [CW-1:0] cnt,
    input  logic          ack,
    input  logic          berr,
    input  logic          done_in,
    output seq_state_e    st,
    output ptr_ctl_t      ctl,
    output logic [1:0]    src_inc,
    output logic          cap_hi,
    output logic          cap_lo,
    output logic          cap_word,
    output stat_t         ev,
    output logic          req,
    output logic          we,
    output logic          done_drv
);

    seq_state_e nxt;
    logic       byte_r;
    logic       step2_r;
    logic       ext_r;
    logic       fin_cnt;
    logic       chk_empty;

    assign chk_empty = byte_r ? (cnt == '0) : (cnt < CW'(2));
    assign src_inc   = src_step(byte_r, step2_r);
    assign req       = (st == ST_RD1) || (st == ST_RD2) || (st == ST_WR);
    assign we        = (st == ST_WR);

    always_comb begin
        nxt      = st;
        ctl      = '0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        cap_word = 1'b0;
        ev       = '0;
        fin_cnt  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    ctl.load = 1'b1;
                    nxt      = ST_CHK;
                end
            end
            ST_CHK: begin
                if (chk_empty) begin
                    ev.fin  = 1'b1;
                    fin_cnt = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    nxt = ST_RD1;
                end
            end
            ST_RD1: begin
                if (berr) begin
                    ev.src_err = 1'b1;
                    nxt        = ST_IDLE;
                end else if (ack) begin
                    ctl.src_adv = 1'b1;
                    if (byte_r) begin
                        cap_hi      = 1'b1;
                        ctl.cnt_dec = 2'd1;
                        if (done_in) begin
                            ev.dns = 1'b1;
                            nxt    = ST_IDLE;
                        end else if (cnt == CW'(1)) begin
                            ev.fin  = 1'b1;
                            fin_cnt = 1'b1;
                            nxt     = ST_IDLE;
                        end else begin
                            nxt = ST_RD2;
                        end
                    end else begin
                        cap_word    = 1'b1;
                        ctl.cnt_dec = 2'd2;
                        nxt         = ST_WR;
                    end
                end
            end
            ST_RD2: begin
                if (berr) begin
                    ev.src_err = 1'b1;
                    nxt        = ST_IDLE;
                end else if (ack) begin
                    ctl.src_adv = 1'b1;
                    cap_lo      = 1'b1;
                    ctl.cnt_dec = 2'd1;
                    nxt         = ST_WR;
                end
            end
            ST_WR: begin
                if (berr) begin
                    ev.dst_err = 1'b1;
                    nxt        = ST_IDLE;
                end else if (ack) begin
                    ctl.dst_adv = 1'b1;
                    if (ext_r || done_in) begin
                        ev.fin = 1'b1;
                        nxt    = ST_IDLE;
                    end else if (cnt == '0) begin
                        ev.fin  = 1'b1;
                        fin_cnt = 1'b1;
                        nxt     = ST_IDLE;
                    end else begin
                        nxt = ST_CHK;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            st       <= ST_IDLE;
            byte_r   <= 1'b0;
            step2_r  <= 1'b0;
            ext_r    <= 1'b0;
            done_drv <= 1'b0;
        end else begin
            st       <= nxt;
            done_drv <= fin_cnt;
            if (ctl.load) begin
                byte_r  <= cfg_byte_mode;
                step2_r <= cfg_src_step2;
                ext_r   <= 1'b0;
            end else if (ack && !berr && ((st == ST_RD2) || (st == ST_RD1 && !byte_r))) begin
                ext_r <= ext_r | done_in;
            end
        end
    end

    // R9: a read error ends the transfer before another request
    assert_rd_err_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (req && !we && berr) |=> (st == ST_IDLE));

    // R10: a write error ends the transfer
    assert_wr_err_stop_R10: assert property (@(posedge clk) disable iff (rst)
        (req && we && berr) |=> (st == ST_IDLE));

    // R8: done on the first byte of a pair stops without a write
    assert_dns_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD1 && byte_r && ack && !berr && done_in) |=> !req);

endmodule

// File: rtl/bpk_dma_channel.sv
module bpk_dma_channel
    import bpk_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chan_rst,
    input  logic              cfg_byte_mode,
    input  logic              cfg_src_step2,
    input  logic [AW-1:0]     cfg_src,
    input  logic [AW-1:0]     cfg_dst,
    input  logic [CW-1:0]     cfg_count,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [7:0]        status,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_berr,
    input  logic              done_in,
    output logic              done_drv
);

    seq_state_e    st;
    ptr_ctl_t      ctl;
    logic [1:0]    src_inc;
    logic          cap_hi;
    logic          cap_lo;
    logic          cap_word;
    stat_t         ev;
    stat_t         stat;
    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;
    logic [CW-1:0] cnt;

    bpk_seq #(.CW(CW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .chan_rst      (chan_rst),
        .cfg_byte_mode (cfg_byte_mode),
        .cfg_src_step2 (cfg_src_step2),
        .cnt           (cnt),
        .ack           (bus_ack),
        .berr          (bus_berr),
        .done_in       (done_in),
        .st            (st),
        .ctl           (ctl),
        .src_inc       (src_inc),
        .cap_hi        (cap_hi),
        .cap_lo        (cap_lo),
        .cap_word      (cap_word),
        .ev            (ev),
        .req           (bus_req),
        .we            (bus_we),
        .done_drv      (done_drv)
    );

    bpk_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .src_inc (src_inc),
        .src_in  (cfg_src),
        .dst_in  (cfg_dst),
        .cnt_in  (cfg_count),
        .src_ptr (src_ptr),
        .dst_ptr (dst_ptr),
        .cnt     (cnt)
    );

    bpk_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .cap_word (cap_word),
        .odd      (src_ptr[0]),
        .rdata    (bus_rdata),
        .pk_word  (bus_wdata)
    );

    bpk_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set      (ev),
        .clr_wr   (clr_wr),
        .clr_mask (stat_t'(clr_mask)),
        .chan_rst (chan_rst),
        .stat     (stat)
    );

    assign busy     = (st != ST_IDLE);
    assign bus_addr = bus_we ? dst_ptr : src_ptr;
    assign status   = {4'b0000, stat};

    // R13: a pending cycle holds its request and address
    assert_hold_req_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !bus_berr && !chan_rst) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R4: destination advances by two after each completed write
    assert_dst_step_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ack && !bus_berr) |=> (dst_ptr == $past(dst_ptr) + AW'(2)));

    // R5: the count-expiry pulse only appears with the channel stopped
    assert_pulse_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done_drv |-> !busy);

    // R5: pulse lasts a single cycle
    assert_pulse_one_R5: assert property (@(posedge clk) disable iff (rst)
        done_drv |=> !done_drv);

endmodule

// File: tb/bpk_dma_channel_bench.sv
module bpk_dma_channel_bench;

    localparam int AW = 24;
    localparam int CW = 16;
    localparam int NV = 11;

    typedef struct packed {
        logic       bm;
        logic       s2;
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] cnt;
        logic [3:0] err_at;
        logic [3:0] done_at;
        logic [1:0] waits;
    } vec_t;

    // mode, step2, src, dst, count, error cycle, done cycle, wait states
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h10, 8'h80, 8'd4, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b1, 8'h21, 8'h90, 8'd4, 4'd0, 4'd0, 2'd1},
        '{1'b0, 1'b0, 8'h40, 8'hA0, 8'd6, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b0, 8'h30, 8'hB0, 8'd3, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b0, 8'h30, 8'hB0, 8'd0, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b0, 8'h50, 8'hC0, 8'd6, 4'd2, 4'd0, 2'd1},
        '{1'b1, 1'b0, 8'h50, 8'hC0, 8'd6, 4'd3, 4'd0, 2'd0},
        '{1'b1, 1'b0, 8'h60, 8'hD0, 8'd8, 4'd0, 4'd4, 2'd0},
        '{1'b1, 1'b0, 8'h60, 8'hD0, 8'd8, 4'd0, 4'd5, 2'd2},
        '{1'b0, 1'b0, 8'h70, 8'hE0, 8'd5, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b1, 8'h12, 8'hF0, 8'd4, 4'd0, 4'd3, 2'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             chan_rst = 1'b0;
    logic             cfg_byte_mode = 1'b0;
    logic             cfg_src_step2 = 1'b0;
    logic [AW-1:0]    cfg_src = '0;
    logic [AW-1:0]    cfg_dst = '0;
    logic [CW-1:0]    cfg_count = '0;
    logic             clr_wr = 1'b0;
    logic [3:0]       clr_mask = '0;
    logic [7:0]       status;
    logic             busy;
    logic             bus_req;
    logic             bus_we;
    logic [AW-1:0]    bus_addr;
    logic [15:0]      bus_wdata;
    logic [15:0]      bus_rdata = '0;
    logic             bus_ack = 1'b0;
    logic             bus_berr = 1'b0;
    logic             done_in = 1'b0;
    logic             done_drv;

    int n_chk = 0;
    int n_fail = 0;
    bit wd_hit = 1'b0;

    logic [AW-1:0] e_ra [40];
    logic [AW-1:0] o_ra [40];
    logic [AW-1:0] e_wa [40];
    logic [AW-1:0] o_wa [40];
    logic [15:0]   e_wd [40];
    logic [15:0]   o_wd [40];
    int e_r, e_w, o_r, o_w, o_pulse;
    logic [7:0] e_stat;
    int e_pulse;

    always #4 clk = ~clk;

    bpk_dma_channel #(.AW(AW), .CW(CW)) u_bpk_dma_channel (
        .clk(clk), .rst(rst), .start(start), .chan_rst(chan_rst),
        .cfg_byte_mode(cfg_byte_mode), .cfg_src_step2(cfg_src_step2),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_berr(bus_berr), .done_in(done_in), .done_drv(done_drv)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [15:0] w;
        w = mem_word(a);
        return a[0] ? w[7:0] : w[15:8];
    endfunction

    function automatic string vec_tag(input int id);
        case (id)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R6";
            5: return "R9";
            6: return "R10";
            7: return "R8";
            8: return "R7";
            9: return "R6";
            10: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic build_model(input vec_t v);
        int cnt;
        int k;
        bit ext;
        bit fin;
        logic [AW-1:0] s;
        logic [AW-1:0] d;
        logic [AW-1:0] stp;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [15:0] w;
        cnt = int'(v.cnt); k = 0; ext = 1'b0; fin = 1'b0;
        s = AW'(v.src); d = AW'(v.dst);
        stp = (!v.bm || v.s2) ? AW'(2) : AW'(1);
        e_r = 0; e_w = 0; e_stat = 8'h00; e_pulse = 0;
        b2 = 8'h00; w = 16'h0000;
        for (int g = 0; g < 40 && !fin; g++) begin
            if (v.bm ? (cnt == 0) : (cnt < 2)) begin
                e_stat = 8'h01; e_pulse = 1; fin = 1'b1;
            end else begin
                k++; e_ra[e_r] = s; e_r++;
                if (k == int'(v.err_at)) begin
                    e_stat = 8'h04; fin = 1'b1;
                end else if (v.bm) begin
                    b1 = mem_byte(s); cnt--; s = s + stp;
                    if (k == int'(v.done_at)) begin
                        e_stat = 8'h08; fin = 1'b1;
                    end else if (cnt == 0) begin
                        e_stat = 8'h01; e_pulse = 1; fin = 1'b1;
                    end else begin
                        k++; e_ra[e_r] = s; e_r++;
                        if (k == int'(v.err_at)) begin
                            e_stat = 8'h04; fin = 1'b1;
                        end else begin
                            b2 = mem_byte(s); cnt--; s = s + stp;
                            if (k == int'(v.done_at)) ext = 1'b1;
                        end
                    end
                    w = {b1, b2};
                end else begin
                    w = mem_word(s); cnt -= 2; s = s + stp;
                    if (k == int'(v.done_at)) ext = 1'b1;
                end
                if (!fin) begin
                    k++; e_wa[e_w] = d; e_wd[e_w] = w; e_w++;
                    if (k == int'(v.err_at)) begin
                        e_stat = 8'h02; fin = 1'b1;
                    end else begin
                        d = d + AW'(2);
                        if (k == int'(v.done_at)) ext = 1'b1;
                        if (ext) begin
                            e_stat = 8'h01; fin = 1'b1;
                        end else if (cnt == 0) begin
                            e_stat = 8'h01; e_pulse = 1; fin = 1'b1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int id, input bit poke);
        int idx;
        int wt;
        string tag;
        tag = vec_tag(id);
        build_model(v);
        @(negedge clk);
        clr_wr = 1'b1; clr_mask = 4'hF;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 4'h0;
        cfg_byte_mode = v.bm; cfg_src_step2 = v.s2;
        cfg_src = AW'(v.src); cfg_dst = AW'(v.dst); cfg_count = CW'(v.cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        o_r = 0; o_w = 0; o_pulse = 0; idx = 0; wt = 0;
        for (int c = 0; c < 400; c++) begin
            bus_ack = 1'b0; bus_berr = 1'b0; done_in = 1'b0; start = 1'b0;
            if (poke && c == 3) begin
                start = 1'b1; cfg_src = AW'(24'h000600);
            end
            if (done_drv) o_pulse++;
            if (bus_req) begin
                if (wt < int'(v.waits)) begin
                    wt++;
                end else begin
                    wt = 0; idx++;
                    if (bus_we) begin
                        if (o_w < 40) begin o_wa[o_w] = bus_addr; o_wd[o_w] = bus_wdata; end
                        o_w++;
                    end else begin
                        if (o_r < 40) o_ra[o_r] = bus_addr;
                        o_r++;
                    end
                    bus_rdata = mem_word(bus_addr);
                    if (idx == int'(v.err_at)) bus_berr = 1'b1;
                    else bus_ack = 1'b1;
                    if (idx == int'(v.done_at)) done_in = 1'b1;
                end
            end else if (!busy && c > 2) begin
                break;
            end
            @(negedge clk);
        end
        bus_ack = 1'b0; bus_berr = 1'b0; done_in = 1'b0;
        check(o_r == e_r, {tag, " read count"}, o_r, e_r);
        for (int i = 0; i < e_r && i < o_r; i++)
            check(o_ra[i] == e_ra[i], {tag, " R4 read address"}, o_ra[i], e_ra[i]);
        check(o_w == e_w, {tag, " write count"}, o_w, e_w);
        for (int i = 0; i < e_w && i < o_w; i++) begin
            check(o_wa[i] == e_wa[i], {tag, " R4 write address"}, o_wa[i], e_wa[i]);
            check(o_wd[i] == e_wd[i], {tag, " R3 packed data"}, o_wd[i], e_wd[i]);
        end
        check(status == e_stat, {tag, " status"}, status, e_stat);
        check(o_pulse == e_pulse, {tag, " R5 done_drv pulses"}, o_pulse, e_pulse);
        check(!busy && !bus_req, {tag, " stopped"}, {busy, bus_req}, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        wd_hit = 1'b1;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !bus_req && !done_drv && status == 8'h00, "R1 reset state",
              {busy, bus_req, done_drv, status}, 0);

        // vector table
        for (int i = 0; i < NV && !wd_hit; i++) run_vec(VECS[i], i, 1'b0);

        // R2: start while busy must not disturb the running transfer
        run_vec(VECS[1], 1, 1'b1);
        check(o_ra[0] == e_ra[0], "R2 restart ignored", o_ra[0], e_ra[0]);

        // R11: write-one-to-clear, after a read error leaves status 0x04
        run_vec(VECS[5], 5, 1'b0);
        @(negedge clk);
        clr_wr = 1'b1; clr_mask = 4'b0011;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 4'h0;
        check(status == 8'h04, "R11 unmasked bit kept", status, 8'h04);
        clr_wr = 1'b1; clr_mask = 4'b0100;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 4'h0;
        check(status == 8'h00, "R11 masked bit cleared", status, 8'h00);
        check(status[7:4] == 4'h0, "R11 reserved bits zero", status[7:4], 0);

        // R12: channel reset mid-transfer with a status bit already set
        run_vec(VECS[0], 0, 1'b0);
        @(negedge clk);
        cfg_byte_mode = 1'b1; cfg_src_step2 = 1'b0;
        cfg_src = AW'(24'h000100); cfg_dst = AW'(24'h000200); cfg_count = CW'(8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_req == 1'b1, "R13 request held without ack", bus_req, 1);
        check(bus_addr == AW'(24'h000100), "R13 address held", bus_addr, 24'h000100);
        chan_rst = 1'b1;
        @(negedge clk);
        chan_rst = 1'b0;
        check(!busy && !bus_req, "R12 idle after channel reset", {busy, bus_req}, 0);
        check(status == 8'h00, "R12 status cleared", status, 8'h00);

        if (wd_hit) check(1'b0, "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(posedge wd_hit);
        check(1'b0, "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule